// File: doc/BRIEF.md
# IrDA Link Frame Wrapper

This block sits between a link-layer byte source or sink and an infrared modulator or demodulator on a half-duplex link. In transmit mode it takes payload bytes from a valid/ready stream and produces the outgoing byte stream. That stream holds an opening flag, the payload, a 16-bit frame check sequence and a closing flag. Bytes that would collide with the flag or escape codes are made transparent with a two-byte escape.

In receive mode it watches the demodulated byte stream. It waits for an opening flag and undoes the escapes. It runs the same 16-bit check over the recovered bytes. The payload is passed on with the two check bytes removed. When the closing flag arrives, the block reports whether the frame is good or bad. A single mode input picks the direction, and the idle direction is held in its reset state.

Top module: `irda_frame_wrapper`

## Requirements
- R1: In transmit mode (mode_rx=0), each frame goes out on tx_out_data in this order: 0xC0, the payload bytes in arrival order, two check bytes, and 0xC1. A payload byte with tx_in_last=1 ends the frame.
- R2: Any payload or check byte equal to 0xC0, 0xC1 or 0x7D is sent as the two bytes 0x7D and (byte XOR 0x20). All other bytes are sent unchanged.
- R3: The check value is the bit-reversed CRC-16 with polynomial x^16+x^12+x^5+1. Bits are processed least significant first (reversed constant 0x8408), starting from 0xFFFF, over the raw payload. Its ones' complement is sent low byte first.
- R4: In receive mode, bytes outside a frame are ignored. Within a frame, 0x7D marks the next byte to be XORed with 0x20. The unescaped bytes, except the last two, come out on rx_out_data/rx_out_valid in order. Each one is presented one cycle after the byte that makes it the third-newest byte.
- R5: One cycle after a 0xC1 received inside a frame, rx_done pulses for one cycle. rx_good is high in that same cycle only when three things hold: at least two unescaped bytes were received, no escape is pending, and the CRC over all unescaped bytes (check bytes included) is 0xF0B8.
- R6: A 0xC0 received inside a frame drops the frame so far and starts a new one, with no rx_done.
- R7: A 0xC1 that ends a frame holding fewer than two unescaped bytes gives rx_done with rx_good low.
- R8: With mode_rx=1, tx_in_ready and tx_out_valid stay low. With mode_rx=0, the receive inputs are ignored: rx_out_valid and rx_done stay low.
- R9: While rst_n is low, and right after it is released, tx_out_valid, tx_in_ready, rx_out_valid, rx_done and rx_good are low.
- R10: tx_in_ready is high only while tx_out_valid and tx_out_ready are high. Under any stall pattern on tx_out_ready the output stream matches R1 to R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rx | input | 1 | 1 = receive, 0 = transmit |
| tx_in_data | input | 8 | Payload byte to send |
| tx_in_valid | input | 1 | Payload byte present |
| tx_in_last | input | 1 | Payload byte is the last of its frame |
| tx_in_ready | output | 1 | Payload byte taken this cycle |
| tx_out_data | output | 8 | Framed byte toward the modulator |
| tx_out_valid | output | 1 | Framed byte present |
| tx_out_ready | input | 1 | Modulator takes the framed byte |
| rx_in_data | input | 8 | Byte from the demodulator |
| rx_in_valid | input | 1 | Demodulated byte present |
| rx_out_data | output | 8 | Recovered payload byte |
| rx_out_valid | output | 1 | Recovered payload byte present |
| rx_done | output | 1 | Closing flag seen, status valid |
| rx_good | output | 1 | Frame check passed (with rx_done) |

## Verification
The bench sends one-byte frames for all 256 payload values. It also decodes frames built from every byte value. This covers the three reserved codes in the payload and many check values that themselves need escaping; a framer that escaped the check bytes wrongly, or computed the CRC before escaping, would give a wrong byte sequence or a bad status. It runs longer frames under a pseudo-random stall on tx_out_ready, which catches a framer that drops or repeats a byte when the stall and an escape pair overlap. It also sends frames that are restarted mid-way, closed too early, closed just after an escape byte, or corrupted. A deframer that misses any of these would emit stale bytes or report a bad frame as good.

// File: rtl/irda_wrap_pkg.sv
package irda_wrap_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CRC_W  = 16;

    localparam logic [BYTE_W-1:0] FLAG_OPEN  = 8'hC0;
    localparam logic [BYTE_W-1:0] FLAG_CLOSE = 8'hC1;
    localparam logic [BYTE_W-1:0] ESC_CODE   = 8'h7D;
    localparam logic [BYTE_W-1:0] ESC_FLIP   = 8'h20;

    localparam logic [CRC_W-1:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_RV = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8;

    // Minimum unescaped bytes between flags for a frame to carry its check.
    localparam int unsigned MIN_BODY = CRC_W / BYTE_W;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_RV) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic is_reserved(input logic [BYTE_W-1:0] b);
        return (b == FLAG_OPEN) || (b == FLAG_CLOSE) || (b == ESC_CODE);
    endfunction

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_OPEN,
        TX_BODY,
        TX_FCS_LO,
        TX_FCS_HI,
        TX_CLOSE
    } tx_state_e;

    typedef struct packed {
        tx_state_e        st;
        logic             esc;
        logic [CRC_W-1:0] crc;
    } tx_regs_t;

    typedef struct packed {
        logic              in_frame;
        logic              esc;
        logic [1:0]        cnt;
        logic [CRC_W-1:0]  crc;
        logic [BYTE_W-1:0] hold0;
        logic [BYTE_W-1:0] hold1;
        logic              out_v;
        logic [BYTE_W-1:0] out_d;
        logic              done;
        logic              good;
    } rx_regs_t;

endpackage

// File: rtl/irda_tx_framer.sv
module irda_tx_framer
    import irda_wrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam tx_regs_t TX_RESET = '{st: TX_IDLE, esc: 1'b0, crc: CRC_PRESET};

    tx_regs_t r_q, r_d;

    logic [BYTE_W-1:0] src_byte;
    logic              src_valid;
    logic              src_stage;
    logic              consumed;

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        src_byte  = '0;
        src_valid = 1'b0;
        src_stage = 1'b0;
        consumed  = 1'b0;

        case (r_q.st)
            TX_IDLE: begin
                if (in_valid) begin
                    r_d.st  = TX_OPEN;
                    r_d.crc = CRC_PRESET;
                    r_d.esc = 1'b0;
                end
            end
            TX_OPEN: begin
                out_valid = 1'b1;
                out_data  = FLAG_OPEN;
                if (out_ready) r_d.st = TX_BODY;
            end
            TX_BODY: begin
                src_stage = 1'b1;
                src_byte  = in_data;
                src_valid = in_valid;
            end
            TX_FCS_LO: begin
                src_stage = 1'b1;
                src_byte  = ~r_q.crc[BYTE_W-1:0];
                src_valid = 1'b1;
            end
            TX_FCS_HI: begin
                src_stage = 1'b1;
                src_byte  = ~r_q.crc[CRC_W-1:BYTE_W];
                src_valid = 1'b1;
            end
            TX_CLOSE: begin
                out_valid = 1'b1;
                out_data  = FLAG_CLOSE;
                if (out_ready) r_d.st = TX_IDLE;
            end
            default: r_d = TX_RESET;
        endcase

        // Shared escape path for payload and check bytes.
        if (src_stage) begin
            out_valid = src_valid;
            if (is_reserved(src_byte) && !r_q.esc) begin
                out_data = ESC_CODE;
                if (src_valid && out_ready) r_d.esc = 1'b1;
            end else begin
                out_data = r_q.esc ? (src_byte ^ ESC_FLIP) : src_byte;
                if (src_valid && out_ready) begin
                    r_d.esc  = 1'b0;
                    consumed = 1'b1;
                end
            end
        end

        if (consumed) begin
            case (r_q.st)
                TX_BODY: begin
                    in_ready = 1'b1;
                    r_d.crc  = crc_step(r_q.crc, src_byte);
                    if (in_last) r_d.st = TX_FCS_LO;
                end
                TX_FCS_LO: r_d.st = TX_FCS_HI;
                TX_FCS_HI: r_d.st = TX_CLOSE;
                default:   r_d.st = r_q.st;
            endcase
        end

        if (!enable) begin
            r_d       = TX_RESET;
            in_ready  = 1'b0;
            out_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= TX_RESET;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/irda_rx_deframer.sv
module irda_rx_deframer
    import irda_wrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              done,
    output logic              good
);

    localparam rx_regs_t RX_RESET = '{
        in_frame: 1'b0, esc: 1'b0, cnt: 2'd0, crc: CRC_PRESET,
        hold0: '0, hold1: '0, out_v: 1'b0, out_d: '0, done: 1'b0, good: 1'b0
    };
    localparam logic [1:0] CNT_FULL = 2'(MIN_BODY);

    rx_regs_t r_q, r_d;
    logic [BYTE_W-1:0] plain;

    always_comb begin
        r_d       = r_q;
        r_d.out_v = 1'b0;
        r_d.done  = 1'b0;
        r_d.good  = 1'b0;
        plain     = r_q.esc ? (in_data ^ ESC_FLIP) : in_data;

        if (!enable) begin
            r_d = RX_RESET;
        end else if (in_valid) begin
            if (in_data == FLAG_OPEN) begin
                r_d.in_frame = 1'b1;
                r_d.esc      = 1'b0;
                r_d.cnt      = '0;
                r_d.crc      = CRC_PRESET;
            end else if (r_q.in_frame) begin
                if (in_data == FLAG_CLOSE) begin
                    r_d.in_frame = 1'b0;
                    r_d.esc      = 1'b0;
                    r_d.done     = 1'b1;
                    r_d.good     = (r_q.cnt == CNT_FULL) && !r_q.esc
                                   && (r_q.crc == CRC_RESIDUE);
                end else if (in_data == ESC_CODE && !r_q.esc) begin
                    r_d.esc = 1'b1;
                end else begin
                    r_d.esc   = 1'b0;
                    r_d.crc   = crc_step(r_q.crc, plain);
                    r_d.hold0 = plain;
                    r_d.hold1 = r_q.hold0;
                    if (r_q.cnt == CNT_FULL) begin
                        r_d.out_v = 1'b1;
                        r_d.out_d = r_q.hold1;
                    end else begin
                        r_d.cnt = r_q.cnt + 2'd1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RX_RESET;
        else        r_q <= r_d;
    end

    assign out_data  = r_q.out_d;
    assign out_valid = r_q.out_v;
    assign done      = r_q.done;
    assign good      = r_q.good;

endmodule

// File: rtl/irda_frame_wrapper.sv
module irda_frame_wrapper
    import irda_wrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_rx,
    input  logic [7:0] tx_in_data,
    input  logic       tx_in_valid,
    input  logic       tx_in_last,
    output logic       tx_in_ready,
    output logic [7:0] tx_out_data,
    output logic       tx_out_valid,
    input  logic       tx_out_ready,
    input  logic [7:0] rx_in_data,
    input  logic       rx_in_valid,
    output logic [7:0] rx_out_data,
    output logic       rx_out_valid,
    output logic       rx_done,
    output logic       rx_good
);

    irda_tx_framer u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!mode_rx),
        .in_data   (tx_in_data),
        .in_valid  (tx_in_valid),
        .in_last   (tx_in_last),
        .in_ready  (tx_in_ready),
        .out_data  (tx_out_data),
        .out_valid (tx_out_valid),
        .out_ready (tx_out_ready)
    );

    irda_rx_deframer u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode_rx),
        .in_data   (rx_in_data),
        .in_valid  (rx_in_valid),
        .out_data  (rx_out_data),
        .out_valid (rx_out_valid),
        .done      (rx_done),
        .good      (rx_good)
    );

endmodule

// File: rtl/irda_frame_wrapper_chk.sv
module irda_frame_wrapper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_rx,
    input logic       tx_in_ready,
    input logic       tx_out_valid,
    input logic       tx_out_ready,
    input logic [7:0] rx_in_data,
    input logic       rx_in_valid,
    input logic       rx_out_valid,
    input logic       rx_done,
    input logic       rx_good
);

    assert_tx_quiet_in_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rx |-> (!tx_out_valid && !tx_in_ready));

    assert_rx_quiet_in_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_rx && !$past(mode_rx)) |-> (!rx_out_valid && !rx_done));

    assert_ready_needs_sink_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_ready |-> (tx_out_valid && tx_out_ready));

    assert_good_only_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_good |-> rx_done);

    assert_done_follows_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(rx_in_valid && rx_in_data == 8'hC1));

    assert_payload_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid |-> $past(rx_in_valid && rx_in_data != 8'hC0 && rx_in_data != 8'hC1));

endmodule

bind irda_frame_wrapper irda_frame_wrapper_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_rx      (mode_rx),
    .tx_in_ready  (tx_in_ready),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .rx_in_data   (rx_in_data),
    .rx_in_valid  (rx_in_valid),
    .rx_out_valid (rx_out_valid),
    .rx_done      (rx_done),
    .rx_good      (rx_good)
);

// File: tb/irda_frame_wrapper_tb.sv
module irda_frame_wrapper_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_rx = 1'b0;
    logic [7:0] tx_in_data = '0;
    logic       tx_in_valid = 1'b0;
    logic       tx_in_last = 1'b0;
    logic       tx_in_ready;
    logic [7:0] tx_out_data;
    logic       tx_out_valid;
    logic       tx_out_ready = 1'b1;
    logic [7:0] rx_in_data = '0;
    logic       rx_in_valid = 1'b0;
    logic [7:0] rx_out_data;
    logic       rx_out_valid;
    logic       rx_done;
    logic       rx_good;

    always #2.5 clk = ~clk;

    irda_frame_wrapper u_dut (
        .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx),
        .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_last(tx_in_last),
        .tx_in_ready(tx_in_ready), .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid),
        .tx_out_ready(tx_out_ready), .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid),
        .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid), .rx_done(rx_done),
        .rx_good(rx_good)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Capture rings, sampled at the falling edge.
    logic [7:0] txcap [0:255];
    logic [7:0] rxcap [0:255];
    int ntx = 0, nrx = 0, ndone = 0;
    logic last_good = 1'b0;
    int ready_viol = 0;

    always @(negedge clk) begin
        if (tx_out_valid && tx_out_ready) begin
            txcap[ntx % 256] <= tx_out_data;
            ntx <= ntx + 1;
        end
        if (rx_out_valid) begin
            rxcap[nrx % 256] <= rx_out_data;
            nrx <= nrx + 1;
        end
        if (rx_done) begin
            ndone <= ndone + 1;
            last_good <= rx_good;
        end
        if (tx_in_ready && !(tx_out_valid && tx_out_ready)) ready_viol <= ready_viol + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act cycles=%0d exp finish earlier", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // Expected frame construction from the requirements.
    logic [7:0] pl   [0:63];
    logic [7:0] expb [0:255];
    int nexp;

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic put_esc(input logic [7:0] b);
        if (b == 8'hC0 || b == 8'hC1 || b == 8'h7D) begin
            expb[nexp] = 8'h7D; nexp++;
            expb[nexp] = b ^ 8'h20; nexp++;
        end else begin
            expb[nexp] = b; nexp++;
        end
    endtask

    task automatic build_frame(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        nexp = 0;
        expb[nexp] = 8'hC0; nexp++;
        for (int i = 0; i < n; i++) begin
            put_esc(pl[i]);
            c = ref_crc(c, pl[i]);
        end
        put_esc(~c[7:0]);
        put_esc(~c[15:8]);
        expb[nexp] = 8'hC1; nexp++;
    endtask

    logic bp_en = 1'b0;
    logic [7:0] lfsr = 8'h5B;

    task automatic step();
        @(posedge clk); #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    endtask

    task automatic send_tx(input int n, input string req);
        int base;
        int guard;
        logic acc;
        logic ok;
        int first_bad;
        build_frame(n);
        base = ntx;
        for (int i = 0; i < n; i++) begin
            tx_in_data  = pl[i];
            tx_in_last  = (i == n - 1);
            tx_in_valid = 1'b1;
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                acc = tx_in_ready;
                step();
            end
        end
        tx_in_valid = 1'b0;
        tx_in_last  = 1'b0;
        guard = 0;
        while (guard < 300 && (ntx == base || txcap[(ntx - 1) % 256] != 8'hC1)) begin
            step();
            guard++;
        end
        ok = (ntx - base == nexp);
        first_bad = -1;
        if (ok) begin
            for (int i = 0; i < nexp; i++) begin
                if (txcap[(base + i) % 256] != expb[i] && first_bad < 0) first_bad = i;
            end
        end
        if (!ok) chk(1'b0, req, ntx - base, nexp);
        else if (first_bad >= 0)
            chk(1'b0, req, int'(txcap[(base + first_bad) % 256]), int'(expb[first_bad]));
        else chk(1'b1, req, 0, 0);
    endtask

    task automatic rx_byte(input logic [7:0] b);
        rx_in_data  = b;
        rx_in_valid = 1'b1;
        @(posedge clk); #1;
        rx_in_valid = 1'b0;
    endtask

    // Sends expb[0..nexp-1], then checks payload count n, content and status.
    task automatic rx_expect(input int n, input logic exp_good, input int exp_done,
                             input string req, input int base_rx, input int base_done);
        logic ok;
        for (int i = 0; i < nexp; i++) rx_byte(expb[i]);
        @(posedge clk); #1;
        @(posedge clk); #1;
        ok = (nrx - base_rx == n);
        for (int i = 0; i < n && ok; i++) ok = (rxcap[(base_rx + i) % 256] == pl[i]);
        chk(ok, {req, " payload"}, nrx - base_rx, n);
        chk(ndone - base_done == exp_done, {req, " done count"}, ndone - base_done, exp_done);
        if (exp_done > 0) chk(last_good == exp_good, {req, " status"}, int'(last_good), int'(exp_good));
    endtask

    initial begin
        int b_rx, b_dn;

        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(!tx_out_valid && !tx_in_ready && !rx_out_valid && !rx_done && !rx_good,
            "R9 in reset", {tx_out_valid, tx_in_ready, rx_out_valid, rx_done, rx_good}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_out_valid && !tx_in_ready && !rx_out_valid && !rx_done && !rx_good,
            "R9 after release", {tx_out_valid, tx_in_ready, rx_out_valid, rx_done, rx_good}, 0);
        step();

        // R1 R2 R3: every one-byte payload value
        for (int v = 0; v < 256; v++) begin
            pl[0] = 8'(v);
            send_tx(1, "R1 R2 R3 single byte");
        end

        // R1 R2 R3 R10: longer frames under stalls on tx_out_ready
        bp_en = 1'b1;
        for (int f = 0; f < 24; f++) begin
            for (int i = 0; i < 40; i++) pl[i] = 8'((f * 53 + i * 37) ^ (i == 3 ? 8'hC0 : 8'h00));
            pl[f % 7] = 8'h7D;
            pl[(f + 2) % 9] = 8'hC1;
            send_tx(f + 1, "R10 R1 R2 stalled frame");
        end
        bp_en = 1'b0;
        step();
        chk(ready_viol == 0, "R10 ready without sink", ready_viol, 0);

        // R8: receive inputs ignored in transmit mode
        b_rx = nrx; b_dn = ndone;
        pl[0] = 8'h41; pl[1] = 8'h42;
        build_frame(2);
        for (int i = 0; i < nexp; i++) rx_byte(expb[i]);
        step(); step();
        chk(nrx == b_rx && ndone == b_dn, "R8 rx ignored in tx mode", nrx - b_rx + ndone - b_dn, 0);

        // Switch to receive mode
        mode_rx = 1'b1;
        step();

        // R8: transmit side silent in receive mode
        begin
            int base_t;
            base_t = ntx;
            tx_in_data = 8'h33; tx_in_valid = 1'b1; tx_in_last = 1'b1;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                chk(!tx_in_ready && !tx_out_valid, "R8 tx silent in rx mode",
                    {tx_in_ready, tx_out_valid}, 0);
                step();
            end
            tx_in_valid = 1'b0; tx_in_last = 1'b0;
            chk(ntx == base_t, "R8 no tx bytes in rx mode", ntx - base_t, 0);
        end

        // R4 R5: two-byte frames over all byte values, with junk before the flag
        for (int v = 0; v < 256; v++) begin
            pl[0] = 8'(v);
            pl[1] = 8'(v) ^ 8'h9C;
            build_frame(2);
            b_rx = nrx; b_dn = ndone;
            rx_byte(8'h11);
            rx_byte(8'h7D);
            rx_expect(2, 1'b1, 1, "R4 R5 sweep", b_rx, b_dn);
        end

        // R5: corrupted payload byte gives bad status
        pl[0] = 8'h41; pl[1] = 8'h42; pl[2] = 8'h43;
        build_frame(3);
        expb[2] = 8'h52;
        pl[1] = 8'h52;
        b_rx = nrx; b_dn = ndone;
        rx_expect(3, 1'b0, 1, "R5 corrupt frame", b_rx, b_dn);

        // R5: escape pending right before closing flag
        b_rx = nrx; b_dn = ndone;
        nexp = 0;
        expb[0] = 8'hC0; expb[1] = 8'h10; expb[2] = 8'h20; expb[3] = 8'h7D; expb[4] = 8'hC1;
        nexp = 5;
        rx_expect(0, 1'b0, 1, "R5 dangling escape", b_rx, b_dn);

        // R6: opening flag mid-frame restarts reception
        b_rx = nrx; b_dn = ndone;
        rx_byte(8'hC0); rx_byte(8'hAA); rx_byte(8'hBB);
        pl[0] = 8'h55;
        build_frame(1);
        rx_expect(1, 1'b1, 1, "R6 restart", b_rx, b_dn);

        // R7: closing flag with too few bytes
        b_rx = nrx; b_dn = ndone;
        expb[0] = 8'hC0; expb[1] = 8'hC1; nexp = 2;
        rx_expect(0, 1'b0, 1, "R7 empty frame", b_rx, b_dn);
        b_rx = nrx; b_dn = ndone;
        expb[0] = 8'hC0; expb[1] = 8'h7D; expb[2] = 8'hE0; expb[3] = 8'hC1; nexp = 4;
        rx_expect(0, 1'b0, 1, "R7 one-byte frame", b_rx, b_dn);

        // R4: closing flag outside a frame is ignored
        b_rx = nrx; b_dn = ndone;
        rx_byte(8'hC1); rx_byte(8'h22);
        step(); step();
        chk(nrx == b_rx && ndone == b_dn, "R4 close outside frame", ndone - b_dn, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule